// File: doc/BRIEF.md
# Bus Access Watchpoint Unit

This block observes every access that a memory arbiter grants and compares it against four independent watchpoints. Each watchpoint holds an inclusive address window, an operation selector (reads, writes or both) and a per-client enable mask. When an access matches, the watchpoint records the access details for software, freezes them, and raises a pending interrupt bit. It does not block or alter the access.

Software programs and inspects the unit through a small word-wide register port with one cycle of read latency. Each watchpoint has its own acknowledge, which releases its captured record. A global acknowledge with one bit per watchpoint clears pending interrupt bits. A global mask gates pending bits into a masked status word, whose OR drives the interrupt line. A priority register names the lowest-numbered masked pending watchpoint, so software services watchpoint 0 before 1, 1 before 2 and 2 before 3.

Register map, with the address 6 bits wide. Watchpoint u occupies word addresses u*8+0 to u*8+7:
- +0 is the first address.
- +1 is the last address.
- +2 is the operation selector: bit 0 enables reads, bit 1 enables writes.
- +3 is the client mask: bit c enables client c.
- +4 holds the captured client bits (read-only).
- +5 holds the captured address (read-only).
- +6 holds the captured info (read-only): bit 0 is 1 for a write, bits 11:8 are the first client, bits 19:16 are the size, bit 31 is the frozen flag.
- +7 is the per-watchpoint acknowledge. Any write to it acknowledges.

The global registers are:
- 0x20 is the interrupt mask, one bit per watchpoint.
- 0x21 is the masked status (read-only).
- 0x22 is the global acknowledge (write 1 to clear).
- 0x23 is the priority register: bit 8 is valid, bits 1:0 are the index.

Top module: `bus_watch_unit`

## Requirements
- R1: After reset every register reads 0, the masked status is 0 and `irq` is low. The operation selectors reset to 0, so no watchpoint can hit until it is programmed.
- R2: An access hits a watchpoint only if its address is at least the first address and at most the last address. Both ends of the window are inclusive.
- R3: A read hits only when selector bit 0 is set. A write hits only when selector bit 1 is set.
- R4: An access hits only when the client mask bit indexed by its client id is set.
- R5: The first hit stores the address, the operation, the client and the size, and sets the frozen flag. While the unit is frozen, later hits leave the address, operation, first client and size unchanged.
- R6: The captured client word has the bit of every client that hit since the last acknowledge, including hits that arrive while the unit is frozen.
- R7: A write to a watchpoint's acknowledge register clears its frozen flag and its capture registers. The next hit is then captured afresh.
- R8: A hit sets that watchpoint's pending bit. The masked status equals pending AND mask. `irq` is the OR of the masked status, delayed by one cycle.
- R9: Writing 1 to bit u of the global acknowledge clears pending bit u. Writing 0 leaves it unchanged. The global acknowledge does not touch the captures.
- R10: The priority register reports the lowest-numbered watchpoint that has a masked pending bit, and sets valid only when one exists.
- R11: If a hit and that watchpoint's acknowledge fall in the same cycle, the unit ends frozen with the new access captured. Its client word then holds only the new client.
- R12: If a hit and a global acknowledge of that watchpoint fall in the same cycle, the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| obs_valid | input | 1 | A granted access is present this cycle |
| obs_addr | input | 32 | Access address |
| obs_client | input | 4 | Id of the client that owns the access |
| obs_write | input | 1 | 1 for a write, 0 for a read |
| obs_size | input | 4 | Access size code |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_re` |
| irq | output | 1 | Registered OR of the masked pending bits |

## Verification
Two pairs of events can land in the same clock: a watchpoint hit and that watchpoint's own acknowledge, and a hit and a global acknowledge of the same bit. The bench provokes each pair by driving the access and the register write on the same clock edge. It then reads back the capture, the frozen flag and the masked status, and compares them with a model in which the acknowledge is applied first and the hit second. Randomly placed acknowledges that coincide with random accesses exercise the same pairs again.

// File: rtl/bwu_pkg.sv
package bwu_pkg;

  typedef enum logic [2:0] {
    UR_FIRST = 3'd0,
    UR_LAST  = 3'd1,
    UR_OPSEL = 3'd2,
    UR_CMASK = 3'd3,
    UR_CAPCL = 3'd4,
    UR_CAPAD = 3'd5,
    UR_INFO  = 3'd6,
    UR_ACK   = 3'd7
  } unit_reg_e;

  typedef enum logic [1:0] {
    GR_MASK  = 2'd0,
    GR_MSTAT = 2'd1,
    GR_GACK  = 2'd2,
    GR_PRIO  = 2'd3
  } glob_reg_e;

  localparam int INFO_OP_BIT   = 0;
  localparam int INFO_CID_LSB  = 8;
  localparam int INFO_SIZE_LSB = 16;
  localparam int PRIO_VLD_BIT  = 8;

endpackage

// File: rtl/bwu_match.sv
module bwu_match #(
  parameter int ADDR_W      = 32,
  parameter int NUM_CLIENTS = 16,
  localparam int CID_W      = $clog2(NUM_CLIENTS)
) (
  input  logic                   obs_valid,
  input  logic [ADDR_W-1:0]      obs_addr,
  input  logic [CID_W-1:0]       obs_client,
  input  logic                   obs_write,
  input  logic [ADDR_W-1:0]      first_addr,
  input  logic [ADDR_W-1:0]      last_addr,
  input  logic [1:0]             opsel,
  input  logic [NUM_CLIENTS-1:0] cmask,
  output logic                   hit
);

  logic in_window;
  logic op_ok;
  logic client_ok;

  always_comb begin
    in_window = (obs_addr >= first_addr) && (obs_addr <= last_addr);
    op_ok     = obs_write ? opsel[1] : opsel[0];
    client_ok = cmask[obs_client];
    hit       = obs_valid && in_window && op_ok && client_ok;
  end

endmodule

// File: rtl/bwu_unit.sv
module bwu_unit
  import bwu_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int NUM_CLIENTS = 16,
  parameter int SIZE_W      = 4,
  localparam int CID_W      = $clog2(NUM_CLIENTS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   obs_valid,
  input  logic [ADDR_W-1:0]      obs_addr,
  input  logic [CID_W-1:0]       obs_client,
  input  logic                   obs_write,
  input  logic [SIZE_W-1:0]      obs_size,
  input  logic                   sel_we,
  input  logic [2:0]             sel_off,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   gack,
  output logic [ADDR_W-1:0]      first_q,
  output logic [ADDR_W-1:0]      last_q,
  output logic [1:0]             opsel_q,
  output logic [NUM_CLIENTS-1:0] cmask_q,
  output logic [NUM_CLIENTS-1:0] cap_clients_q,
  output logic [ADDR_W-1:0]      cap_addr_q,
  output logic                   cap_write_q,
  output logic [CID_W-1:0]       cap_client_q,
  output logic [SIZE_W-1:0]      cap_size_q,
  output logic                   frozen_q,
  output logic                   pend_q,
  output logic                   hit_o,
  output logic                   ack_o
);

  logic                   hit;
  logic                   ack;
  logic [NUM_CLIENTS-1:0] client_bit;

  bwu_match #(
    .ADDR_W      (ADDR_W),
    .NUM_CLIENTS (NUM_CLIENTS)
  ) u_match (
    .obs_valid  (obs_valid),
    .obs_addr   (obs_addr),
    .obs_client (obs_client),
    .obs_write  (obs_write),
    .first_addr (first_q),
    .last_addr  (last_q),
    .opsel      (opsel_q),
    .cmask      (cmask_q),
    .hit        (hit)
  );

  always_comb begin
    ack        = sel_we && (unit_reg_e'(sel_off) == UR_ACK);
    client_bit = {{(NUM_CLIENTS-1){1'b0}}, 1'b1} << obs_client;
    hit_o      = hit;
    ack_o      = ack;
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      last_q  <= '0;
      opsel_q <= '0;
      cmask_q <= '0;
    end else if (sel_we) begin
      case (unit_reg_e'(sel_off))
        UR_FIRST: first_q <= wdata[ADDR_W-1:0];
        UR_LAST:  last_q  <= wdata[ADDR_W-1:0];
        UR_OPSEL: opsel_q <= wdata[1:0];
        UR_CMASK: cmask_q <= wdata[NUM_CLIENTS-1:0];
        default:  ;
      endcase
    end
  end

  // capture: a hit that meets an idle or just-acknowledged unit is stored
  always_ff @(posedge clk) begin
    if (rst) begin
      frozen_q      <= 1'b0;
      cap_clients_q <= '0;
      cap_addr_q    <= '0;
      cap_write_q   <= 1'b0;
      cap_client_q  <= '0;
      cap_size_q    <= '0;
    end else if (hit && (!frozen_q || ack)) begin
      frozen_q      <= 1'b1;
      cap_clients_q <= client_bit;
      cap_addr_q    <= obs_addr;
      cap_write_q   <= obs_write;
      cap_client_q  <= obs_client;
      cap_size_q    <= obs_size;
    end else if (ack) begin
      frozen_q      <= 1'b0;
      cap_clients_q <= '0;
      cap_addr_q    <= '0;
      cap_write_q   <= 1'b0;
      cap_client_q  <= '0;
      cap_size_q    <= '0;
    end else if (hit) begin
      cap_clients_q <= cap_clients_q | client_bit;
    end
  end

  // pending interrupt bit: set wins over the global acknowledge
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (hit) begin
      pend_q <= 1'b1;
    end else if (gack) begin
      pend_q <= 1'b0;
    end
  end

endmodule

// File: rtl/bwu_prio.sv
module bwu_prio #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx
);

  always_comb begin
    valid = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/bus_watch_unit.sv
module bus_watch_unit
  import bwu_pkg::*;
#(
  parameter int NUM_WP      = 4,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int NUM_CLIENTS = 16,
  parameter int SIZE_W      = 4,
  localparam int CID_W      = $clog2(NUM_CLIENTS),
  localparam int UIW        = (NUM_WP > 1) ? $clog2(NUM_WP) : 1,
  localparam int REG_AW     = UIW + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              obs_valid,
  input  logic [ADDR_W-1:0] obs_addr,
  input  logic [CID_W-1:0]  obs_client,
  input  logic              obs_write,
  input  logic [SIZE_W-1:0] obs_size,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);

  logic            glob_sel;
  logic [UIW-1:0]  unit_idx;
  logic [2:0]      unit_off;
  logic [1:0]      glob_off;

  logic [NUM_WP-1:0][ADDR_W-1:0]      first_v;
  logic [NUM_WP-1:0][ADDR_W-1:0]      last_v;
  logic [NUM_WP-1:0][1:0]             opsel_v;
  logic [NUM_WP-1:0][NUM_CLIENTS-1:0] cmask_v;
  logic [NUM_WP-1:0][NUM_CLIENTS-1:0] capcl_v;
  logic [NUM_WP-1:0][ADDR_W-1:0]      cap_addr_v;
  logic [NUM_WP-1:0]                  capwr_v;
  logic [NUM_WP-1:0][CID_W-1:0]       capcid_v;
  logic [NUM_WP-1:0][SIZE_W-1:0]      capsz_v;
  logic [NUM_WP-1:0]                  frozen_v;
  logic [NUM_WP-1:0]                  pend_v;
  logic [NUM_WP-1:0]                  hit_v;
  logic [NUM_WP-1:0]                  ack_v;
  logic [NUM_WP-1:0]                  mask_q;
  logic [NUM_WP-1:0]                  masked_v;
  logic                               prio_valid;
  logic [UIW-1:0]                     prio_idx;
  logic                               gack_we;
  logic [DATA_W-1:0]                  rd_mux;
  logic [DATA_W-1:0]                  info_w;

  always_comb begin
    glob_sel = reg_addr[REG_AW-1];
    unit_idx = reg_addr[3 +: UIW];
    unit_off = reg_addr[2:0];
    glob_off = reg_addr[1:0];
    gack_we  = reg_we && glob_sel && (glob_reg_e'(glob_off) == GR_GACK);
  end

  for (genvar u = 0; u < NUM_WP; u++) begin : g_unit
    logic sel_we_u;
    assign sel_we_u = reg_we && !glob_sel && (unit_idx == UIW'(u));

    bwu_unit #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .NUM_CLIENTS (NUM_CLIENTS),
      .SIZE_W      (SIZE_W)
    ) u_unit (
      .clk           (clk),
      .rst           (rst),
      .obs_valid     (obs_valid),
      .obs_addr      (obs_addr),
      .obs_client    (obs_client),
      .obs_write     (obs_write),
      .obs_size      (obs_size),
      .sel_we        (sel_we_u),
      .sel_off       (unit_off),
      .wdata         (reg_wdata),
      .gack          (gack_we && reg_wdata[u]),
      .first_q       (first_v[u]),
      .last_q        (last_v[u]),
      .opsel_q       (opsel_v[u]),
      .cmask_q       (cmask_v[u]),
      .cap_clients_q (capcl_v[u]),
      .cap_addr_q    (cap_addr_v[u]),
      .cap_write_q   (capwr_v[u]),
      .cap_client_q  (capcid_v[u]),
      .cap_size_q    (capsz_v[u]),
      .frozen_q      (frozen_v[u]),
      .pend_q        (pend_v[u]),
      .hit_o         (hit_v[u]),
      .ack_o         (ack_v[u])
    );
  end

  assign masked_v = pend_v & mask_q;

  bwu_prio #(.N(NUM_WP)) u_prio (
    .req   (masked_v),
    .valid (prio_valid),
    .idx   (prio_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (reg_we && glob_sel && (glob_reg_e'(glob_off) == GR_MASK)) begin
      mask_q <= reg_wdata[NUM_WP-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |masked_v;
  end

  always_comb begin
    info_w                              = '0;
    info_w[INFO_OP_BIT]                 = capwr_v[unit_idx];
    info_w[INFO_CID_LSB +: CID_W]       = capcid_v[unit_idx];
    info_w[INFO_SIZE_LSB +: SIZE_W]     = capsz_v[unit_idx];
    info_w[DATA_W-1]                    = frozen_v[unit_idx];
    rd_mux = '0;
    if (glob_sel) begin
      case (glob_reg_e'(glob_off))
        GR_MASK:  rd_mux = DATA_W'(mask_q);
        GR_MSTAT: rd_mux = DATA_W'(masked_v);
        GR_PRIO: begin
          rd_mux               = DATA_W'(prio_idx);
          rd_mux[PRIO_VLD_BIT] = prio_valid;
        end
        default:  rd_mux = '0;
      endcase
    end else begin
      case (unit_reg_e'(unit_off))
        UR_FIRST: rd_mux = DATA_W'(first_v[unit_idx]);
        UR_LAST:  rd_mux = DATA_W'(last_v[unit_idx]);
        UR_OPSEL: rd_mux = DATA_W'(opsel_v[unit_idx]);
        UR_CMASK: rd_mux = DATA_W'(cmask_v[unit_idx]);
        UR_CAPCL: rd_mux = DATA_W'(capcl_v[unit_idx]);
        UR_CAPAD: rd_mux = DATA_W'(cap_addr_v[unit_idx]);
        UR_INFO:  rd_mux = info_w;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/bus_watch_unit_chk.sv
module bus_watch_unit_chk #(
  parameter int NUM_WP = 4,
  parameter int ADDR_W = 32,
  localparam int UIW   = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         irq,
  input logic [NUM_WP-1:0]            pend,
  input logic [NUM_WP-1:0]            masked,
  input logic [NUM_WP-1:0]            frozen,
  input logic [NUM_WP-1:0]            hit,
  input logic [NUM_WP-1:0]            ack,
  input logic [NUM_WP-1:0][ADDR_W-1:0] cap_addr,
  input logic                         prio_valid,
  input logic [UIW-1:0]               prio_idx
);

  AST_IRQ_HAS_PEND: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|pend)); // R8

  AST_PRIO_PICKS_SET: assert property (@(posedge clk) disable iff (rst)
    prio_valid |-> masked[prio_idx]); // R10

  AST_PRIO_IS_LOWEST: assert property (@(posedge clk) disable iff (rst)
    prio_valid |-> ((masked & ((NUM_WP'(1) << prio_idx) - NUM_WP'(1))) == '0)); // R10

  for (genvar u = 0; u < NUM_WP; u++) begin : g_chk
    AST_FROZEN_ADDR_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (frozen[u] && !ack[u]) |=> $stable(cap_addr[u])); // R5

    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
      (ack[u] && !hit[u]) |=> !frozen[u]); // R7

    AST_HIT_WINS_UACK: assert property (@(posedge clk) disable iff (rst)
      hit[u] |=> frozen[u]); // R11

    AST_HIT_WINS_GACK: assert property (@(posedge clk) disable iff (rst)
      hit[u] |=> pend[u]); // R12
  end

endmodule

bind bus_watch_unit bus_watch_unit_chk #(
  .NUM_WP (NUM_WP),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq        (irq),
  .pend       (pend_v),
  .masked     (masked_v),
  .frozen     (frozen_v),
  .hit        (hit_v),
  .ack        (ack_v),
  .cap_addr   (cap_addr_v),
  .prio_valid (prio_valid),
  .prio_idx   (prio_idx)
);

// File: tb/bus_watch_unit_test.sv
`timescale 1ns/1ps
module bus_watch_unit_test;

  localparam int NWP = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        obs_valid = 1'b0;
  logic [31:0] obs_addr = '0;
  logic [3:0]  obs_client = '0;
  logic        obs_write = 1'b0;
  logic [3:0]  obs_size = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  bus_watch_unit uut (
    .clk(clk), .rst(rst), .obs_valid(obs_valid), .obs_addr(obs_addr),
    .obs_client(obs_client), .obs_write(obs_write), .obs_size(obs_size),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  // model state
  logic [31:0] m_lo [NWP];
  logic [31:0] m_hi [NWP];
  logic [1:0]  m_op [NWP];
  logic [15:0] m_cm [NWP];
  logic        m_frz [NWP];
  logic [15:0] m_cl [NWP];
  logic [31:0] m_ad [NWP];
  logic        m_wr [NWP];
  logic [3:0]  m_cid [NWP];
  logic [3:0]  m_sz [NWP];
  logic [NWP-1:0] m_pend;
  logic [NWP-1:0] m_mask;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic m_match(int u, logic [31:0] a, logic [3:0] c, logic w);
    return (a >= m_lo[u]) && (a <= m_hi[u]) && m_cm[u][c] && (w ? m_op[u][1] : m_op[u][0]);
  endfunction

  function automatic logic [31:0] m_info(int u);
    logic [31:0] v = '0;
    v[0] = m_wr[u];
    v[11:8] = m_cid[u];
    v[19:16] = m_sz[u];
    v[31] = m_frz[u];
    return v;
  endfunction

  function automatic logic [31:0] m_prio();
    logic [31:0] v = '0;
    logic [NWP-1:0] mv = m_pend & m_mask;
    for (int i = NWP - 1; i >= 0; i--) if (mv[i]) begin v[1:0] = 2'(i); v[8] = 1'b1; end
    return v;
  endfunction

  task automatic m_reset();
    for (int u = 0; u < NWP; u++) begin
      m_lo[u] = '0; m_hi[u] = '0; m_op[u] = '0; m_cm[u] = '0;
      m_frz[u] = 0; m_cl[u] = '0; m_ad[u] = '0; m_wr[u] = 0; m_cid[u] = '0; m_sz[u] = '0;
    end
    m_pend = '0; m_mask = '0;
  endtask

  task automatic m_uack(int u);
    m_frz[u] = 0; m_cl[u] = '0; m_ad[u] = '0; m_wr[u] = 0; m_cid[u] = '0; m_sz[u] = '0;
  endtask

  task automatic m_access(logic [31:0] a, logic [3:0] c, logic w, logic [3:0] s);
    for (int u = 0; u < NWP; u++) begin
      if (m_match(u, a, c, w)) begin
        if (!m_frz[u]) begin
          m_frz[u] = 1; m_ad[u] = a; m_wr[u] = w; m_cid[u] = c; m_sz[u] = s;
          m_cl[u] = 16'(1) << c;
        end else begin
          m_cl[u] = m_cl[u] | (16'(1) << c);
        end
        m_pend[u] = 1'b1;
      end
    end
  endtask

  // model side effect of a register write
  task automatic m_write(logic [5:0] a, logic [31:0] d);
    if (a[5]) begin
      if (a[1:0] == 2'd0) m_mask = d[NWP-1:0];
      else if (a[1:0] == 2'd2) m_pend = m_pend & ~d[NWP-1:0];
    end else begin
      case (a[2:0])
        3'd0: m_lo[a[4:3]] = d;
        3'd1: m_hi[a[4:3]] = d;
        3'd2: m_op[a[4:3]] = d[1:0];
        3'd3: m_cm[a[4:3]] = d[15:0];
        3'd7: m_uack(int'(a[4:3]));
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    m_write(a, d);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  // access, optionally with a coincident register write
  task automatic access(input logic [31:0] a, input logic [3:0] c, input logic w,
                        input logic [3:0] s, input logic do_wr,
                        input logic [5:0] ra, input logic [31:0] rdv);
    @(negedge clk);
    obs_valid = 1'b1; obs_addr = a; obs_client = c; obs_write = w; obs_size = s;
    reg_we = do_wr; reg_addr = ra; reg_wdata = rdv;
    @(negedge clk);
    obs_valid = 1'b0; reg_we = 1'b0;
    if (do_wr) m_write(ra, rdv);
    m_access(a, c, w, s);
  endtask

  task automatic acc(input logic [31:0] a, input logic [3:0] c, input logic w, input logic [3:0] s);
    access(a, c, w, s, 1'b0, 6'd0, 32'd0);
  endtask

  task automatic cfg(int u, logic [31:0] lo, logic [31:0] hi, logic [1:0] op, logic [15:0] cm);
    wr(6'(u*8 + 0), lo);
    wr(6'(u*8 + 1), hi);
    wr(6'(u*8 + 2), 32'(op));
    wr(6'(u*8 + 3), 32'(cm));
  endtask

  task automatic verify_unit(int u, string tag);
    logic [31:0] d;
    rd(6'(u*8 + 4), d); check({tag, " clients"}, d, 32'(m_cl[u]));
    rd(6'(u*8 + 5), d); check({tag, " addr"}, d, m_ad[u]);
    rd(6'(u*8 + 6), d); check({tag, " info"}, d, m_info(u));
  endtask

  task automatic verify_glob(string tag);
    logic [31:0] d;
    rd(6'h21, d); check({tag, " mstat"}, d, 32'(m_pend & m_mask));
    check({tag, " irq"}, 32'(irq), 32'(|(m_pend & m_mask)));
    rd(6'h23, d); check({tag, " prio"}, d, m_prio());
  endtask

  initial begin : watchdog
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    void'($urandom(32'd20240611));
    m_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", 32'(irq), 32'd0);
    rd(6'h20, d); check("R1 mask", d, 32'd0);
    rd(6'h02, d); check("R1 opsel", d, 32'd0);
    verify_unit(0, "R1");
    verify_glob("R1");
    acc(32'd0, 4'd0, 1'b0, 4'd1);
    verify_unit(0, "R1 unprogrammed no hit");

    // R2 inclusive window bounds
    cfg(0, 32'h100, 32'h1FF, 2'b01, 16'h0004);
    acc(32'h0FF, 4'd2, 1'b0, 4'd2); verify_unit(0, "R2 below");
    acc(32'h200, 4'd2, 1'b0, 4'd2); verify_unit(0, "R2 above");
    acc(32'h100, 4'd2, 1'b0, 4'd3); verify_unit(0, "R2 first edge");
    wr(6'h07, 32'd1);
    acc(32'h1FF, 4'd2, 1'b0, 4'd5); verify_unit(0, "R2 last edge");
    wr(6'h07, 32'd1);

    // R3 operation selector
    acc(32'h120, 4'd2, 1'b1, 4'd1); verify_unit(0, "R3 write disabled");
    wr(6'h02, 32'd2);
    acc(32'h121, 4'd2, 1'b0, 4'd1); verify_unit(0, "R3 read disabled");
    acc(32'h122, 4'd2, 1'b1, 4'd6); verify_unit(0, "R3 write enabled");
    wr(6'h07, 32'd1);
    wr(6'h02, 32'd1);

    // R4 client mask
    acc(32'h130, 4'd3, 1'b0, 4'd1); verify_unit(0, "R4 client masked");

    // R5 freeze, R6 client accumulation
    acc(32'h150, 4'd2, 1'b0, 4'd4);
    wr(6'h03, 32'h000C);
    acc(32'h160, 4'd3, 1'b0, 4'd7);
    rd(6'h05, d); check("R5 frozen addr", d, 32'h150);
    rd(6'h06, d); check("R5 frozen info", d, 32'h8004_0200);
    rd(6'h04, d); check("R6 clients", d, 32'h000C);

    // R7 unit acknowledge
    wr(6'h07, 32'd0);
    verify_unit(0, "R7 cleared");
    acc(32'h170, 4'd3, 1'b0, 4'd2); verify_unit(0, "R7 recapture");

    // R8 mask gating, R9 global acknowledge
    verify_glob("R8 masked off");
    wr(6'h20, 32'd1);
    verify_glob("R8 masked on");
    wr(6'h22, 32'd0); verify_glob("R9 zero bit");
    wr(6'h22, 32'd1); verify_glob("R9 cleared");
    verify_unit(0, "R9 capture kept");
    wr(6'h07, 32'd1);

    // R10 priority
    cfg(2, 32'h400, 32'h4FF, 2'b11, 16'hFFFF);
    cfg(3, 32'h480, 32'h5FF, 2'b11, 16'hFFFF);
    wr(6'h20, 32'hF);
    acc(32'h490, 4'd9, 1'b1, 4'd2);
    rd(6'h23, d); check("R10 prio two", d, 32'h102);
    verify_glob("R10");
    wr(6'h22, 32'd4);
    rd(6'h23, d); check("R10 prio three", d, 32'h103);
    wr(6'h22, 32'hF);
    rd(6'h23, d); check("R10 prio none", d, 32'h000);

    // R11 hit coincides with unit acknowledge
    access(32'h4A0, 4'd5, 1'b0, 4'd8, 1'b1, 6'h17, 32'd1);
    verify_unit(2, "R11 coincident ack");
    rd(6'h14, d); check("R11 clients new only", d, 32'h0020);

    // R12 hit coincides with global acknowledge
    access(32'h4B0, 4'd6, 1'b0, 4'd1, 1'b1, 6'h22, 32'h4);
    verify_glob("R12 pend kept");
    rd(6'h21, d); check("R12 bit2", d & 32'h4, 32'h4);

    // random phase
    for (int it = 0; it < 300; it++) begin
      int u = $urandom % NWP;
      if ($urandom % 4 == 0) begin
        logic [31:0] lo = $urandom % 256;
        cfg(u, lo, lo + ($urandom % 64), 2'($urandom), 16'($urandom));
      end
      if ($urandom % 5 == 0) wr(6'h20, 32'($urandom % 16));
      begin
        logic [31:0] a = $urandom % 330;
        logic [3:0] c = 4'($urandom);
        logic w = 1'($urandom);
        logic [3:0] s = 4'($urandom);
        int k = $urandom % 6;
        if (k == 0)      access(a, c, w, s, 1'b1, 6'(u*8 + 7), 32'd0);
        else if (k == 1) access(a, c, w, s, 1'b1, 6'h22, 32'($urandom % 16));
        else             acc(a, c, w, s);
      end
      verify_unit(u, "R5 R6 R11 random");
      verify_glob("R8 R10 R12 random");
      if ($urandom % 3 == 0) wr(6'(u*8 + 7), 32'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule